// File: doc/BRIEF.md
# SPI Codec Control Register File

This block sits between a serial control port and the audio datapath of a codec. An SPI master sends fixed 16-bit command frames. Each frame names one register, says whether it is a read or a write, and carries a 10-bit value. The block keeps eleven 10-bit mode registers and drives them in parallel to the datapath. It also holds two 6-bit peak-level registers that a level detector feeds. Software reads the peak registers through the same port, and each read clears the register it reads so that a new peak can build up.

All logic runs on one system clock. The SPI pins are synchronised into that clock domain and their edges are detected there. The SPI clock must therefore be well below the system clock: each SPI clock half period must last several system clock cycles. A frame takes effect when its sixteenth bit arrives. The read value for a frame is captured once its first six bits are in, and it is shifted out during the rest of that same frame.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: A frame is 16 bits long and is sent MSB first in SPI mode 0. MOSI is sampled on each rising SCLK edge while CS_n is low. Bits 15:12 hold the register address. Bit 11 is 1 for a read and 0 for a write. Bit 10 is reserved. Bits 9:0 hold the data.
- R2: A write frame with the reserved bit at 0 and an address from 0 to 10 loads bits 9:0 into that mode register. The register appears at `mode_regs[addr*10 +: 10]` once the sixteenth bit has been taken.
- R3: After reset, mode registers 2 to 7 (the channel volumes) hold 1023 and all other mode registers hold 0. Both peak registers hold 63, the quietest code.
- R4: In every frame, the register contents addressed by bits 15:12 are driven on MISO during data bit times 9 down to 0, MSB first. MISO changes on falling SCLK edges. MISO is 0 during bits 15:10 and while CS_n is high.
- R5: Peak register 0 is at address 11 and peak register 1 is at address 12. A read returns the 6-bit code in bits 9:4, with bits 3:0 at 0. On each cycle that `peak_vld[p]` is high, register p keeps the smaller of its stored code and `peak_lvl[p]`. A smaller code means a louder level.
- R6: A completed read frame of a peak address resets that register to 63 and pulses its `peak_clr` bit for one cycle. If a new level arrives on that same cycle, the register takes the new level.
- R7: Writes to addresses 11 to 15 change no register. Reads of addresses 13 to 15 return 0.
- R8: A frame whose reserved bit is 1 changes no register, clears no peak register, and returns 0 on MISO.
- R9: A frame in which CS_n rises before the sixteenth bit arrives is discarded and changes no register.
- R10: SCLK edges after the sixteenth bit, while CS_n stays low, are ignored. The first 16 bits alone decide what the frame does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| mode_regs | output | 110 | Mode register m at bits m*10+9 : m*10 |
| peak_lvl | input | 12 | Level code for peak register p at bits p*6+5 : p*6 |
| peak_vld | input | 2 | Level code valid, one bit per peak register |
| peak_clr | output | 2 | One-cycle pulse when a peak register is cleared by a read |

## Verification
Some properties are checked on every cycle. Mode registers change only on the cycle after a frame completes, and never for a frame whose reserved bit is set. A stored peak code never rises except on the cycle that clears it. At most one clear pulse is active at a time. MISO stays 0 through the header bits, and the bit counter never passes sixteen. The bench scenarios cover what needs a whole transaction to show: the values read back, reset defaults, the clear-after-read sequence, and that ignored addresses, reserved-bit frames, short frames and long frames leave every register as it was.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
    localparam int FRAME_W   = 16;
    localparam int DATA_W    = 10;
    localparam int ADDR_W    = 4;
    localparam int PEAK_W    = 6;
    localparam int NUM_MODE  = 11;
    localparam int NUM_PEAK  = 2;
    localparam int VOL_BASE  = 2;
    localparam int NUM_VOL   = 6;
    localparam int HDR_BITS  = FRAME_W - DATA_W;
    localparam int PEAK_BASE = NUM_MODE;
    localparam int PEAK_PAD  = DATA_W - PEAK_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              rsv;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/cctl_sync.sv
module cctl_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/cctl_spi_rx.sv
module cctl_spi_rx
    import cctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output logic              hdr_rsv_o,
    output logic              done_o,
    output frame_t            frame_o,
    output logic              miso_o
);
    typedef struct packed {
        logic               sclk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  rd_sh;
        logic               miso;
        logic               hdr_vld;
        logic               done;
    } rx_t;

    rx_t st_d, st_q;
    logic rise, fall;

    assign rise = sclk_i & ~st_q.sclk_prev;
    assign fall = ~sclk_i & st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.hdr_vld   = 1'b0;
        st_d.done      = 1'b0;
        if (cs_n_i) begin
            st_d.cnt   = '0;
            st_d.miso  = 1'b0;
            st_d.rd_sh = '0;
        end else begin
            if (rise && st_q.cnt < CNT_W'(FRAME_W)) begin
                st_d.sh  = {st_q.sh[FRAME_W-2:0], mosi_i};
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(HDR_BITS - 1)) st_d.hdr_vld = 1'b1;
                if (st_q.cnt == CNT_W'(FRAME_W - 1))  st_d.done    = 1'b1;
            end
            if (fall && st_q.cnt >= CNT_W'(HDR_BITS) && st_q.cnt < CNT_W'(FRAME_W)) begin
                st_d.miso  = st_q.rd_sh[DATA_W-1];
                st_d.rd_sh = {st_q.rd_sh[DATA_W-2:0], 1'b0};
            end
            if (st_q.hdr_vld) st_d.rd_sh = rd_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_addr_o = st_q.sh[HDR_BITS-1:2];
    assign hdr_rsv_o  = st_q.sh[0];
    assign done_o     = st_q.done;
    assign frame_o    = frame_t'(st_q.sh);
    assign miso_o     = st_q.miso;

    // R4
    miso_quiet_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt < CNT_W'(HDR_BITS)) |-> !st_q.miso);

    // R10
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAME_W));
endmodule

// File: rtl/cctl_regbank.sv
module cctl_regbank
    import cctl_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   hdr_addr_i,
    input  logic                                hdr_rsv_i,
    output logic [DATA_W-1:0]                   rd_word_o,
    input  logic                                commit_i,
    input  frame_t                              frame_i,
    input  logic [NUM_PEAK-1:0][PEAK_W-1:0]     peak_lvl_i,
    input  logic [NUM_PEAK-1:0]                 peak_vld_i,
    output logic [NUM_MODE-1:0][DATA_W-1:0]     mode_o,
    output logic [NUM_PEAK-1:0]                 peak_clr_o
);
    typedef struct packed {
        logic [NUM_MODE-1:0][DATA_W-1:0] mode;
        logic [NUM_PEAK-1:0][PEAK_W-1:0] peak;
        logic [NUM_PEAK-1:0]             clr;
    } bank_t;

    function automatic bank_t bank_rst();
        bank_t b;
        b = '0;
        for (int m = 0; m < NUM_MODE; m++)
            if (m >= VOL_BASE && m < VOL_BASE + NUM_VOL) b.mode[m] = '1;
        b.peak = '1;
        return b;
    endfunction

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = '0;
        for (int p = 0; p < NUM_PEAK; p++)
            if (peak_vld_i[p] && peak_lvl_i[p] < st_q.peak[p]) st_d.peak[p] = peak_lvl_i[p];
        if (commit_i && !frame_i.rsv) begin
            for (int m = 0; m < NUM_MODE; m++)
                if (!frame_i.rd && int'(frame_i.addr) == m) st_d.mode[m] = frame_i.data;
            for (int p = 0; p < NUM_PEAK; p++)
                if (frame_i.rd && int'(frame_i.addr) == PEAK_BASE + p) begin
                    st_d.clr[p]  = 1'b1;
                    st_d.peak[p] = peak_vld_i[p] ? peak_lvl_i[p] : '1;
                end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= bank_rst();
        else        st_q <= st_d;
    end

    always_comb begin
        rd_word_o = '0;
        if (!hdr_rsv_i) begin
            for (int m = 0; m < NUM_MODE; m++)
                if (int'(hdr_addr_i) == m) rd_word_o = st_q.mode[m];
            for (int p = 0; p < NUM_PEAK; p++)
                if (int'(hdr_addr_i) == PEAK_BASE + p)
                    rd_word_o = {st_q.peak[p], {PEAK_PAD{1'b0}}};
        end
    end

    assign mode_o     = st_q.mode;
    assign peak_clr_o = st_q.clr;

    logic [NUM_MODE-1:0][DATA_W-1:0] mode_w;
    logic [NUM_PEAK-1:0][PEAK_W-1:0] pk_w;
    assign mode_w = st_q.mode;
    assign pk_w   = st_q.peak;

    // R2
    mode_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mode_w));

    // R8
    mode_hold_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && frame_i.rsv) |=> $stable(mode_w));

    // R6
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(peak_clr_o));

    for (genvar p = 0; p < NUM_PEAK; p++) begin : g_pk_chk
        // R5
        peak_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !peak_clr_o[p] |-> (pk_w[p] <= $past(pk_w[p])));
    end
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
    import cctl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    output logic [NUM_MODE*DATA_W-1:0]    mode_regs,
    input  logic [NUM_PEAK*PEAK_W-1:0]    peak_lvl,
    input  logic [NUM_PEAK-1:0]           peak_vld,
    output logic [NUM_PEAK-1:0]           peak_clr
);
    logic [2:0]                      pins_s;
    logic [DATA_W-1:0]               rd_word;
    logic [ADDR_W-1:0]               hdr_addr;
    logic                            hdr_rsv;
    logic                            done;
    frame_t                          frame;
    logic [NUM_MODE-1:0][DATA_W-1:0] mode_w;
    logic [NUM_PEAK-1:0][PEAK_W-1:0] lvl_w;

    assign lvl_w     = peak_lvl;
    assign mode_regs = mode_w;

    cctl_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q_o   (pins_s)
    );

    cctl_spi_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (pins_s[2]),
        .cs_n_i     (pins_s[1]),
        .mosi_i     (pins_s[0]),
        .rd_word_i  (rd_word),
        .hdr_addr_o (hdr_addr),
        .hdr_rsv_o  (hdr_rsv),
        .done_o     (done),
        .frame_o    (frame),
        .miso_o     (spi_miso)
    );

    cctl_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_addr_i (hdr_addr),
        .hdr_rsv_i  (hdr_rsv),
        .rd_word_o  (rd_word),
        .commit_i   (done),
        .frame_i    (frame),
        .peak_lvl_i (lvl_w),
        .peak_vld_i (peak_vld),
        .mode_o     (mode_w),
        .peak_clr_o (peak_clr)
    );
endmodule

// File: tb/sim_codec_ctrl_regfile.sv
`timescale 1ns/1ps
module sim_codec_ctrl_regfile;
    localparam int HALF = 50;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         miso;
    logic [109:0] mode_regs;
    logic [11:0]  peak_lvl = '0;
    logic [1:0]   peak_vld = '0;
    logic [1:0]   peak_clr;

    int tests = 0, fails = 0;
    int clr_cnt [2];
    logic [9:0] mdl_mode [11];
    logic [5:0] mdl_peak [2];
    bit finished = 0;

    always #2.5 clk = ~clk;

    codec_ctrl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .mode_regs(mode_regs),
        .peak_lvl(peak_lvl), .peak_vld(peak_vld), .peak_clr(peak_clr)
    );

    always @(negedge clk) begin
        if (peak_clr[0]) clr_cnt[0]++;
        if (peak_clr[1]) clr_cnt[1]++;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int addr, input bit rd, input bit rsv, input int data);
        return {addr[3:0], rd, rsv, data[9:0]};
    endfunction

    task automatic xfer(input logic [31:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[nbits-1-i];
            #HALF;
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
        #HALF;
        cs_n = 1'b1;
        #(4*HALF);
    endtask

    task automatic rd_reg(input int addr, output logic [15:0] rx);
        xfer({16'h0, mk(addr, 1, 0, 0)}, 16, rx);
    endtask

    task automatic wr_reg(input int addr, input int data);
        logic [15:0] rx;
        xfer({16'h0, mk(addr, 0, 0, data)}, 16, rx);
        if (addr < 11) mdl_mode[addr] = data[9:0];
    endtask

    task automatic cmp_modes(input string req);
        for (int m = 0; m < 11; m++)
            chk(req, int'(mode_regs[m*10 +: 10]), int'(mdl_mode[m]));
    endtask

    task automatic push_peak(input int ch, input int val);
        @(negedge clk);
        peak_lvl[ch*6 +: 6] = val[5:0];
        peak_vld[ch] = 1'b1;
        @(negedge clk);
        peak_vld[ch] = 1'b0;
        if (val[5:0] < mdl_peak[ch]) mdl_peak[ch] = val[5:0];
    endtask

    task automatic t_reset();
        logic [15:0] rx;
        chk("R4 idle miso", int'(miso), 0);
        cmp_modes("R3 defaults");
        rd_reg(2, rx);  chk("R3 volume default", int'(rx[9:0]), 1023);
        rd_reg(7, rx);  chk("R3 volume default", int'(rx[9:0]), 1023);
        rd_reg(0, rx);  chk("R3 ctrl default", int'(rx[9:0]), 0);
        rd_reg(11, rx); chk("R3 peak default", int'(rx[9:0]), 63*16);
    endtask

    task automatic t_write_read();
        logic [15:0] rx;
        wr_reg(0, 10'h2AA);
        wr_reg(7, 10'h155);
        wr_reg(10, 10'h3FF);
        wr_reg(3, 10'h001);
        cmp_modes("R2 write field");
        rd_reg(0, rx);  chk("R2 readback", int'(rx[9:0]), 'h2AA);
        chk("R4 header miso zero", int'(rx[15:10]), 0);
        rd_reg(7, rx);  chk("R1 R4 readback", int'(rx[9:0]), 'h155);
        rd_reg(10, rx); chk("R2 readback", int'(rx[9:0]), 'h3FF);
        rd_reg(3, rx);  chk("R2 readback", int'(rx[9:0]), 1);
    endtask

    task automatic t_peak();
        logic [15:0] rx;
        int c0;
        push_peak(0, 40); push_peak(0, 20); push_peak(0, 30);
        push_peak(1, 5);
        c0 = clr_cnt[0];
        rd_reg(11, rx); chk("R5 peak min", int'(rx[9:0]), 20*16);
        chk("R6 clear pulse", clr_cnt[0] - c0, 1);
        mdl_peak[0] = 63;
        rd_reg(11, rx); chk("R6 cleared", int'(rx[9:0]), 63*16);
        rd_reg(12, rx); chk("R5 peak ch1", int'(rx[9:0]), 5*16);
        mdl_peak[1] = 63;
        chk("R5 low bits zero", int'(rx[3:0]), 0);
        rd_reg(12, rx); chk("R6 cleared ch1", int'(rx[9:0]), 63*16);
    endtask

    task automatic t_ignored();
        logic [15:0] rx;
        push_peak(0, 12);
        wr_reg(11, 10'h000);
        wr_reg(12, 10'h000);
        wr_reg(13, 10'h123);
        wr_reg(15, 10'h3FF);
        cmp_modes("R7 ignored write");
        rd_reg(13, rx); chk("R7 unused read", int'(rx[9:0]), 0);
        rd_reg(14, rx); chk("R7 unused read", int'(rx[9:0]), 0);
        rd_reg(15, rx); chk("R7 unused read", int'(rx[9:0]), 0);
        rd_reg(11, rx); chk("R7 peak kept", int'(rx[9:0]), 12*16);
        mdl_peak[0] = 63;
    endtask

    task automatic t_reserved();
        logic [15:0] rx;
        int c1;
        xfer({16'h0, mk(1, 0, 1, 10'h0F0)}, 16, rx);
        cmp_modes("R8 rsv write dropped");
        push_peak(1, 9);
        c1 = clr_cnt[1];
        xfer({16'h0, mk(12, 1, 1, 0)}, 16, rx);
        chk("R8 rsv read zero", int'(rx[9:0]), 0);
        chk("R8 no clear pulse", clr_cnt[1] - c1, 0);
        rd_reg(12, rx); chk("R8 peak kept", int'(rx[9:0]), 9*16);
        mdl_peak[1] = 63;
    endtask

    task automatic t_short();
        logic [15:0] rx;
        xfer({20'h0, mk(4, 0, 0, 10'h0AB) >> 4}, 12, rx);
        xfer({17'h0, mk(5, 0, 0, 10'h0CD) >> 1}, 15, rx);
        cmp_modes("R9 short frame");
        rd_reg(4, rx); chk("R9 reg unchanged", int'(rx[9:0]), 1023);
    endtask

    task automatic t_long();
        logic [15:0] rx;
        xfer({12'h0, mk(8, 0, 0, 10'h19C), 4'hF}, 20, rx);
        mdl_mode[8] = 10'h19C;
        cmp_modes("R10 long frame");
        rd_reg(8, rx); chk("R10 readback", int'(rx[9:0]), 'h19C);
    endtask

    initial begin
        for (int m = 0; m < 11; m++) mdl_mode[m] = (m >= 2 && m < 8) ? 10'h3FF : 10'h0;
        mdl_peak[0] = 63; mdl_peak[1] = 63;
        clr_cnt[0] = 0; clr_cnt[1] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_peak();
        t_ignored();
        t_reserved();
        t_short();
        t_long();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule